// File: doc/BRIEF.md
# Reset Release and Output Sequencer

This block turns two active-low reset inputs into an ordered release sequence for a device. One input is a power-on reset and the other a warm reset. Each input is synchronized to the single device clock and filtered by a minimum assertion width, so that short glitches leave the sequence untouched. When a qualifying reset is released, the block captures a 16-bit boot configuration bus. It then times the release of a tri-statable reset-output pin and presents the captured configuration to the rest of the chip.

The reset-output pin is described by two separate signals, an output enable and a data level. The time until the pin goes high depends on the reset source. A power-on release waits a long fixed interval. A warm release stretches the total pulse to a minimum length, so a short warm reset adds delay and a long one adds none. While the release is pending, one bit of the captured configuration decides the pin's state: either it is driven low, or it floats until it is driven high. A separate I/O-hold indication tells the pads when to stay in their reset state.

All delays are counted in device clock periods. The block has no streaming data path: every port is a plain level signal.

Top module: `rst_release_seq`

## Requirements
- R1: While the synchronized power-on reset is low, `rout_oe` and `rout_dat` are 0 and `io_hold` is 1. This takes effect as soon as `pwr_rst_n` falls, without waiting for a clock edge.
- R2: A power-on assertion restarts sequencing only if `pwr_rst_n` is sampled low on at least POR_MIN (12) consecutive rising edges. A shorter assertion leaves the sequence state, the latched configuration, and the pin level after the release point unchanged.
- R3: A warm assertion sampled low on fewer than WARM_MIN (2) rising edges is ignored. The pin stays high and the latched configuration is unchanged.
- R4: For a qualifying warm assertion, `rout_oe` is 0 after the third rising edge that follows the first edge sampling `warm_rst_n` low.
- R5: At the release point, `boot_cfg` takes the value `boot_cfg_in` had at the last rising edge that sampled the reset low. Later changes of `boot_cfg_in` do not affect it until the next qualified release.
- R6: Between the release point and the pin going high, latched bit SEL_BIT (11) = 1 gives `rout_oe`=1 and `rout_dat`=0. Bit 11 = 0 gives `rout_oe`=0.
- R7: The release point is the third rising edge after the last edge that samples the reset low. After a power-on release, the pin goes high (`rout_oe`=1, `rout_dat`=1) at the POR_DELAY-th (12500) edge after the release point.
- R8: Let W be the number of edges a warm assertion was sampled low, saturating at 32. After a warm release, the pin goes high at the release point if W >= 30. Otherwise it goes high 32 - W edges after it.
- R9: Power-on reset takes priority over warm reset. A qualifying warm reset during the power-on delay cancels that delay, and the pin follows the warm rule of R8 from the warm release.
- R10: `io_hold` is 1 while either reset is in its qualified held state. It is 0 from the release point on.
- R11: Once high, the pin stays driven high until the next qualifying reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| pwr_rst_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low, asynchronous |
| boot_cfg_in | input | 16 | Boot configuration bus, captured at reset release |
| rout_oe | output | 1 | Output enable of the reset-output pin |
| rout_dat | output | 1 | Level driven on the reset-output pin when enabled |
| io_hold | output | 1 | I/O reset indication, active high |
| boot_cfg | output | 16 | Latched boot configuration |

## Verification
The bench builds the block with POR_DELAY set to 40 and leaves every other parameter at its default. This makes each power-on sequence last only tens of cycles. With that setting, every warm width from 1 to 36 can be swept: the glitch, the stretch region, the no-delay region at 30 and 31, and saturation beyond 32. Every power-on width from 1 to 14 is swept across its qualification boundary. Separate cases cover the hi-Z latency of a warm assertion and a warm reset that cuts a power-on delay short.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [1:0] {
    SEQ_POR_HOLD  = 2'd0,
    SEQ_WARM_HOLD = 2'd1,
    SEQ_DELAY     = 2'd2,
    SEQ_RUN       = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rrs_sync.sv
// Multi-stage synchronizer with asynchronous clear to zero.
module rrs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rrs_pipe.sv
// Fixed-depth delay line that aligns a bus with the synchronized reset.
module rrs_pipe #(
  parameter int W     = 16,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [DEPTH-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    st <= {st[DEPTH-2:0], d};
  end

  assign q = st[DEPTH-1];
endmodule

// File: rtl/rrs_hold_cnt.sv
// Counts cycles a synchronized reset is low; saturates at MAX, clears when high.
module rrs_hold_cnt #(
  parameter int MAX = 32,
  localparam int CW = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          lo,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CAP = CW'(MAX);

  always_ff @(posedge clk) begin
    if (!lo)             cnt <= '0;
    else if (cnt != CAP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
  import rrs_pkg::*;
#(
  parameter int BOOT_W      = 16,
  parameter int SEL_BIT     = 11,
  parameter int SYNC_STAGES = 2,
  parameter int POR_MIN     = 12,
  parameter int WARM_MIN    = 2,
  parameter int POR_DELAY   = 12500,
  parameter int WARM_PULSE  = 32,
  parameter int WARM_FULL   = 30
) (
  input  logic              clk,
  input  logic              pwr_rst_n,
  input  logic              warm_rst_n,
  input  logic [BOOT_W-1:0] boot_cfg_in,
  output logic              rout_oe,
  output logic              rout_dat,
  output logic              io_hold,
  output logic [BOOT_W-1:0] boot_cfg
);
  // Power-on sync clears asynchronously, so its low window is SYNC_STAGES longer.
  localparam int POR_Q   = POR_MIN + SYNC_STAGES;
  localparam int PCNT_W  = $clog2(POR_Q + 1);
  localparam int WCNT_W  = $clog2(WARM_PULSE + 1);
  localparam int DLY_MAX = (POR_DELAY > WARM_PULSE) ? POR_DELAY : WARM_PULSE;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);

  localparam logic [PCNT_W-1:0] POR_QM1  = PCNT_W'(POR_Q - 1);
  localparam logic [WCNT_W-1:0] WARM_QM1 = WCNT_W'(WARM_MIN - 1);
  localparam logic [WCNT_W-1:0] WFULL    = WCNT_W'(WARM_FULL);
  localparam logic [WCNT_W-1:0] WCAP     = WCNT_W'(WARM_PULSE);
  localparam logic [DLY_W-1:0]  PDLY     = DLY_W'(POR_DELAY);
  localparam logic [DLY_W-1:0]  WPULSE   = DLY_W'(WARM_PULSE);

  logic              por_s, warm_s;
  logic [PCNT_W-1:0] por_cnt;
  logic [WCNT_W-1:0] warm_cnt;
  logic [BOOT_W-1:0] boot_d;
  logic [DLY_W-1:0]  dly;
  seq_state_e        state;

  rrs_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .clr_n(pwr_rst_n), .d(1'b1), .q(por_s)
  );

  rrs_sync #(.STAGES(SYNC_STAGES)) u_warm_sync (
    .clk(clk), .clr_n(1'b1), .d(warm_rst_n), .q(warm_s)
  );

  rrs_hold_cnt #(.MAX(POR_Q)) u_por_cnt (
    .clk(clk), .lo(!por_s), .cnt(por_cnt)
  );

  rrs_hold_cnt #(.MAX(WARM_PULSE)) u_warm_cnt (
    .clk(clk), .lo(!warm_s), .cnt(warm_cnt)
  );

  // One stage beyond the synchronizer: captures the bus at the last low sample.
  rrs_pipe #(.W(BOOT_W), .DEPTH(SYNC_STAGES + 1)) u_boot_pipe (
    .clk(clk), .d(boot_cfg_in), .q(boot_d)
  );

  // Sequencing state is defined by the first qualified power-on assertion,
  // so that sub-minimum glitches never disturb it.
  always_ff @(posedge clk) begin
    if (!por_s) begin
      if (por_cnt >= POR_QM1) state <= SEQ_POR_HOLD;
    end else if (state == SEQ_POR_HOLD) begin
      boot_cfg <= boot_d;
      dly      <= PDLY;
      state    <= (POR_DELAY == 0) ? SEQ_RUN : SEQ_DELAY;
    end else if (!warm_s && (warm_cnt >= WARM_QM1)) begin
      state <= SEQ_WARM_HOLD;
    end else if (state == SEQ_WARM_HOLD) begin
      boot_cfg <= boot_d;
      if (warm_cnt >= WFULL) begin
        state <= SEQ_RUN;
      end else begin
        dly   <= WPULSE - DLY_W'(warm_cnt);
        state <= SEQ_DELAY;
      end
    end else if (state == SEQ_DELAY) begin
      dly <= dly - 1'b1;
      if (dly <= DLY_W'(1)) state <= SEQ_RUN;
    end
  end

  assign rout_oe  = por_s && ((state == SEQ_RUN) ||
                              ((state == SEQ_DELAY) && boot_cfg[SEL_BIT]));
  assign rout_dat = por_s && (state == SEQ_RUN);
  assign io_hold  = !por_s || (state == SEQ_POR_HOLD) || (state == SEQ_WARM_HOLD);

  AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!por_s)
    ((state == SEQ_RUN) && ($past(state) != SEQ_RUN)) |->
      (($past(state) == SEQ_DELAY) && ($past(dly) == DLY_W'(1))) ||
      (($past(state) == SEQ_WARM_HOLD) && ($past(warm_cnt) >= WFULL)) ||
      (($past(state) == SEQ_POR_HOLD) && (POR_DELAY == 0))); // R8

  AST_DELAY_STEP: assert property (@(posedge clk) disable iff (!por_s)
    ((state == SEQ_DELAY) && ($past(state) == SEQ_DELAY) && $past(por_s)) |->
      (dly == $past(dly) - 1'b1)); // R7

  AST_BOOT_HOLD: assert property (@(posedge clk) disable iff (!por_s)
    (((state == SEQ_DELAY) || (state == SEQ_RUN)) &&
     (($past(state) == SEQ_DELAY) || ($past(state) == SEQ_RUN))) |->
      $stable(boot_cfg)); // R5

  AST_WARM_HIZ: assert property (@(posedge clk) disable iff (!por_s)
    (por_s && !warm_s && $past(!warm_s) && (state != SEQ_POR_HOLD)) |=>
      !rout_oe); // R4

  AST_WCNT_SAT: assert property (@(posedge clk) disable iff (!por_s)
    warm_cnt <= WCAP); // R8
endmodule

// File: tb/rst_release_seq_test.sv
module rst_release_seq_test;
  localparam int PDLY = 40;

  logic        clk = 1'b0;
  logic        pwr_rst_n, warm_rst_n;
  logic [15:0] boot_cfg_in;
  logic        rout_oe, rout_dat, io_hold;
  logic [15:0] boot_cfg;

  int errs = 0;
  int nchk = 0;

  always #2 clk = ~clk;

  rst_release_seq #(.POR_DELAY(PDLY)) uut (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .warm_rst_n(warm_rst_n),
    .boot_cfg_in(boot_cfg_in), .rout_oe(rout_oe), .rout_dat(rout_dat),
    .io_hold(io_hold), .boot_cfg(boot_cfg)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic int warm_delay(input int w);
    int s;
    s = (w > 32) ? 32 : w;
    return (s >= 30) ? 0 : 32 - s;
  endfunction

  function automatic logic [15:0] pat(input int w);
    logic [15:0] v;
    v     = 16'(w * 16'h2F1B + 16'h1357);
    v[11] = w[0];
    return v;
  endfunction

  function automatic int pin_high();
    return int'(rout_oe && rout_dat);
  endfunction

  // From a negedge: hold warm low for w sampled edges, then release.
  task automatic warm_pulse(input int w, input logic [15:0] v);
    boot_cfg_in = v;
    warm_rst_n  = 1'b0;
    step(w);
    warm_rst_n  = 1'b1;
    boot_cfg_in = ~v;
  endtask

  // Called at the negedge after the last low sample; d = expected delay.
  task automatic follow(input int d, input logic [15:0] v, input string tag);
    step(2);
    check({tag, " R10 held io_hold"}, int'(io_hold), 1);
    check({tag, " held pin not enabled"}, int'(rout_oe), 0);
    step(1);
    if (d > 0) begin
      check("R6 delay oe follows bit 11", int'(rout_oe), int'(v[11]));
      check("R6 delay data low", int'(rout_dat), 0);
      check("R10 io_hold released", int'(io_hold), 0);
      check("R5 latched config", int'(boot_cfg), int'(v));
      step(d - 1);
      check({tag, " not yet high"}, pin_high(), 0);
      step(1);
    end
    check({tag, " high at delay"}, pin_high(), 1);
    check("R5 latched config after", int'(boot_cfg), int'(v));
    step(5);
    check("R11 stays high", pin_high(), 1);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errs++;
    nchk++;
    $display("FAIL R11 watchdog: actual=timeout expected=finished");
    $display("  Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    logic [15:0] v, prev;
    pwr_rst_n   = 1'b1;
    warm_rst_n  = 1'b1;
    boot_cfg_in = pat(1);
    #1 pwr_rst_n = 1'b0;
    @(negedge clk);
    step(2);
    check("R1 reset oe", int'(rout_oe), 0);
    check("R1 reset data", int'(rout_dat), 0);
    check("R1 reset io_hold", int'(io_hold), 1);
    step(18);
    pwr_rst_n   = 1'b1;
    boot_cfg_in = ~pat(1);
    follow(PDLY, pat(1), "R7");

    // R4: hi-Z latency of a warm assertion
    boot_cfg_in = pat(7);
    warm_rst_n  = 1'b0;
    step(3);
    check("R4 still driven before qualify", int'(rout_oe), 1);
    step(1);
    check("R4 hi-Z at third edge", int'(rout_oe), 0);
    warm_rst_n  = 1'b1;
    boot_cfg_in = ~pat(7);
    follow(warm_delay(4), pat(7), "R8");

    // R3 / R8: every warm width
    for (int w = 1; w <= 36; w++) begin
      v    = pat(w);
      prev = boot_cfg;
      warm_pulse(w, v);
      if (w < 2) begin
        for (int i = 0; i < 4; i++) begin
          check("R3 glitch keeps pin high", pin_high(), 1);
          step(1);
        end
        check("R3 glitch keeps config", int'(boot_cfg), int'(prev));
      end else begin
        follow(warm_delay(w), v, "R8");
      end
      step(2);
    end

    // R1 / R2 / R7: every power-on width across the boundary
    for (int w = 1; w <= 14; w++) begin
      v           = pat(w + 50);
      prev        = boot_cfg;
      boot_cfg_in = v;
      pwr_rst_n   = 1'b0;
      step(1);
      check("R1 oe off while held", int'(rout_oe), 0);
      check("R10 io_hold while held", int'(io_hold), 1);
      step(w - 1);
      pwr_rst_n   = 1'b1;
      boot_cfg_in = ~v;
      if (w < 12) begin
        step(3);
        check("R2 short assertion keeps pin high", pin_high(), 1);
        check("R2 short assertion keeps config", int'(boot_cfg), int'(prev));
      end else begin
        follow(PDLY, v, "R7");
        check("R2 qualified assertion restarts", int'(boot_cfg), int'(v));
      end
      step(2);
    end

    // R9: warm reset during the power-on delay
    boot_cfg_in = pat(90);
    pwr_rst_n   = 1'b0;
    step(20);
    pwr_rst_n   = 1'b1;
    boot_cfg_in = ~pat(90);
    step(10);
    warm_pulse(5, pat(91));
    follow(warm_delay(5), pat(91), "R9");
    check("R9 config from warm release", int'(boot_cfg), int'(pat(91)));

    $display("  Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule